// File: doc/BRIEF.md
# Buffered Serial Transmitter with Empty Flags and Trigger Interrupt

This block is the transmit half of an asynchronous serial port. A host pushes bytes through a simple write strobe. The bytes queue in a first-in first-out buffer and then pass one at a time into a shift register. The shift register drives the serial line. Each character goes out as one low start bit, eight data bits with the least significant bit first, and one high stop bit. When nothing is being sent, the line rests high. Bit timing comes from an external oversampling tick. A mode input sets each bit to 16 ticks or to 8 ticks.

Two status outputs tell the host how far transmission has progressed. The first reports that the queue holds no waiting byte. The second reports that the shift register has finished its last stop bit. An interrupt tells the host when to refill. In buffered mode it is raised when the queue occupancy drops below a programmable threshold. A half-duplex mode input changes the interrupt source to "shifter and queue both empty", so that a line driver can be released only after the final stop bit. With buffering disabled, the queue behaves as a single holding byte. A write that finds no room is discarded and sets a sticky overflow flag.

Top module: `uart_txq`

## Requirements
- R1: After reset, `txd` is 1, `thr_empty` and `tsr_empty` are 1, and `irq`, `overflow` and `fifo_count` are 0.
- R2: Each character appears on `txd` as a 0 start bit, then data bits 0 through 7 in that order, then a 1 stop bit. `txd` is 1 whenever `tsr_empty` is 1.
- R3: With `os8_mode`=1 every bit lasts 8 ticks, and with `os8_mode`=0 it lasts 16 ticks. Ticks are counted only while the shifter is busy, so a lone character keeps `tsr_empty` low for exactly 10 bit times of ticks.
- R4: With `fifo_en`=1 the queue accepts DEPTH bytes beyond the one in the shifter. `fifo_count` reports the queued bytes, and the bytes go out in write order.
- R5: `thr_empty` is 1 exactly when `fifo_count` is 0. `tsr_empty` stays 0 until the stop bit of the last character has fully elapsed.
- R6: With `fifo_en`=0 the holding stage stores one byte. When the shifter is idle, a written byte moves to the shifter on the next clock, and `thr_empty` returns to 1.
- R7: A write made while the queue is at capacity (DEPTH bytes with `fifo_en`=1, one byte with `fifo_en`=0) is discarded. `overflow` then becomes 1 and stays 1 until reset.
- R8: With `fifo_en`=1 and `halfdup_en`=0, an interrupt becomes pending when `fifo_count` changes from at least `trig_level` to below it. The first interrupt of a draining queue therefore appears with `fifo_count` = `trig_level`-1.
- R9: With `fifo_en`=0 and `halfdup_en`=0, an interrupt becomes pending when the holding stage becomes empty.
- R10: With `halfdup_en`=1, an interrupt becomes pending only when the shifter and the queue are both empty, which is after the last stop bit.
- R11: `irq` shows the pending interrupt only while `irq_en` is 1. A pending interrupt is kept while `irq_en` is 0, and it appears once `irq_en` is set.
- R12: A pulse on `irq_ack` or `wr_en` clears the pending interrupt. A new pending event in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1 = queued mode, 0 = single holding byte |
| os8_mode | input | 1 | 1 = 8 ticks per bit, 0 = 16 ticks per bit |
| halfdup_en | input | 1 | Interrupt source becomes shifter-and-queue empty |
| trig_level | input | CNT_W | Occupancy threshold for the interrupt |
| irq_en | input | 1 | Interrupt output enable |
| tick | input | 1 | Oversampling tick, one clock wide |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | DATA_W | Byte to transmit |
| irq_ack | input | 1 | Host read of interrupt status, clears pending |
| txd | output | 1 | Serial line, idles high |
| thr_empty | output | 1 | No byte waiting in the queue |
| tsr_empty | output | 1 | Shifter idle, last stop bit complete |
| irq | output | 1 | Transmit-empty interrupt |
| overflow | output | 1 | Sticky dropped-write indication |
| fifo_count | output | CNT_W | Bytes waiting in the queue |

## Verification
The bench builds the block with DEPTH=8, so CNT_W is 4. This small depth lets it fill the queue past capacity and check that the order is kept and that the sticky overflow is set. It also lets the bench sweep every trigger level from 1 to DEPTH and confirm that the first interrupt always comes at occupancy `trig_level`-1. Frames are decoded from the line in both tick rates, and the bench counts busy ticks to confirm exact frame length. The half-duplex source is compared against the normal source on the same traffic, and gating and both clear paths are exercised.

// File: rtl/uart_txq_pkg.sv
`timescale 1ns/1ps
package uart_txq_pkg;

    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_START = 2'd1,
        SH_DATA  = 2'd2,
        SH_STOP  = 2'd3
    } sh_state_e;

    localparam int TICK_CNT_W = 4;

    // index of the final tick inside one bit cell
    function automatic logic [TICK_CNT_W-1:0] bit_last_tick(input logic fast);
        return fast ? TICK_CNT_W'(7) : TICK_CNT_W'(15);
    endfunction

endpackage

// File: rtl/uart_txq_fifo.sv
`timescale 1ns/1ps
module uart_txq_fifo #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count
);

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] count;
    } fifo_st_t;

    fifo_st_t st_q, st_d;
    logic [DATA_W-1:0] mem_q [DEPTH];

    function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) st_d.wptr = ptr_step(st_q.wptr);
        if (pop)  st_d.rptr = ptr_step(st_q.rptr);
        st_d.count = st_q.count + CNT_W'(push) - CNT_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[st_q.wptr] <= push_data;
    end

    assign head  = mem_q[st_q.rptr];
    assign count = st_q.count;

endmodule

// File: rtl/uart_txq_shifter.sv
`timescale 1ns/1ps
module uart_txq_shifter
    import uart_txq_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              os8,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              txd,
    output logic              busy,
    output logic              frame_end
);

    typedef struct packed {
        sh_state_e             state;
        logic [TICK_CNT_W-1:0] tcnt;
        logic [BIT_W-1:0]      bitn;
        logic [DATA_W-1:0]     sh;
    } sh_st_t;

    sh_st_t st_q, st_d;
    logic   bit_end;

    always_comb begin
        st_d      = st_q;
        bit_end   = tick && (st_q.tcnt >= bit_last_tick(os8));
        frame_end = (st_q.state == SH_STOP) && bit_end;

        if (st_q.state != SH_IDLE && tick)
            st_d.tcnt = bit_end ? '0 : st_q.tcnt + TICK_CNT_W'(1);

        unique case (st_q.state)
            SH_START: if (bit_end) begin
                st_d.state = SH_DATA;
                st_d.bitn  = '0;
            end
            SH_DATA: if (bit_end) begin
                st_d.sh = st_q.sh >> 1;
                if (st_q.bitn == BIT_W'(DATA_W - 1)) st_d.state = SH_STOP;
                else st_d.bitn = st_q.bitn + BIT_W'(1);
            end
            SH_STOP: if (bit_end) st_d.state = SH_IDLE;
            default: ;
        endcase

        if (load) begin
            st_d.state = SH_START;
            st_d.tcnt  = '0;
            st_d.bitn  = '0;
            st_d.sh    = load_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{state: SH_IDLE, default: '0};
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (st_q.state)
            SH_START: txd = 1'b0;
            SH_DATA:  txd = st_q.sh[0];
            default:  txd = 1'b1;
        endcase
    end

    assign busy = (st_q.state != SH_IDLE);

endmodule

// File: rtl/uart_txq_irq.sv
`timescale 1ns/1ps
module uart_txq_irq #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             halfdup_en,
    input  logic [CNT_W-1:0] trig_level,
    input  logic [CNT_W-1:0] count,
    input  logic             shifter_idle,
    input  logic             irq_en,
    input  logic             wr_en,
    input  logic             irq_ack,
    output logic             irq
);

    typedef struct packed {
        logic cond_prev;
        logic pend;
    } irq_st_t;

    irq_st_t st_q, st_d;
    logic    cond;
    logic    rise;

    always_comb begin
        if (halfdup_en)   cond = shifter_idle && (count == '0);
        else if (fifo_en) cond = (count < trig_level);
        else              cond = (count == '0);

        rise           = cond && !st_q.cond_prev;
        st_d.cond_prev = cond;
        if (rise)                  st_d.pend = 1'b1;
        else if (wr_en || irq_ack) st_d.pend = 1'b0;
        else                       st_d.pend = st_q.pend;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{cond_prev: 1'b1, pend: 1'b0};
        else        st_q <= st_d;
    end

    assign irq = st_q.pend && irq_en;

endmodule

// File: rtl/uart_txq.sv
`timescale 1ns/1ps
module uart_txq #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic              os8_mode,
    input  logic              halfdup_en,
    input  logic [CNT_W-1:0]  trig_level,
    input  logic              irq_en,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              irq_ack,
    output logic              txd,
    output logic              thr_empty,
    output logic              tsr_empty,
    output logic              irq,
    output logic              overflow,
    output logic [CNT_W-1:0]  fifo_count
);

    typedef struct packed {
        logic ovf;
    } top_st_t;

    top_st_t st_q, st_d;

    logic              full;
    logic              push;
    logic              pop;
    logic              sh_busy;
    logic              sh_frame_end;
    logic [DATA_W-1:0] head;
    logic [CNT_W-1:0]  count;

    always_comb begin
        full     = fifo_en ? (count == CNT_W'(DEPTH)) : (count != '0);
        push     = wr_en && !full;
        pop      = (!sh_busy || sh_frame_end) && (count != '0);
        st_d     = st_q;
        if (wr_en && full) st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    uart_txq_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (wr_data),
        .pop       (pop),
        .head      (head),
        .count     (count)
    );

    uart_txq_shifter #(.DATA_W(DATA_W)) shifter_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .os8       (os8_mode),
        .load      (pop),
        .load_data (head),
        .txd       (txd),
        .busy      (sh_busy),
        .frame_end (sh_frame_end)
    );

    uart_txq_irq #(.CNT_W(CNT_W)) irq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .fifo_en      (fifo_en),
        .halfdup_en   (halfdup_en),
        .trig_level   (trig_level),
        .count        (count),
        .shifter_idle (!sh_busy),
        .irq_en       (irq_en),
        .wr_en        (wr_en),
        .irq_ack      (irq_ack),
        .irq          (irq)
    );

    assign thr_empty  = (count == '0);
    assign tsr_empty  = !sh_busy;
    assign overflow   = st_q.ovf;
    assign fifo_count = count;

endmodule

// File: rtl/uart_txq_chk.sv
`timescale 1ns/1ps
module uart_txq_chk #(
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_en,
    input logic             halfdup_en,
    input logic [CNT_W-1:0] trig_level,
    input logic             irq_en,
    input logic             wr_en,
    input logic             txd,
    input logic             tsr_empty,
    input logic             irq,
    input logic             overflow,
    input logic [CNT_W-1:0] fifo_count
);

    // R2: an idle shifter leaves the line high
    assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tsr_empty |-> txd);

    // R2: a frame opens with a low start bit
    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tsr_empty) |-> !txd);

    // R4: occupancy never exceeds the queue depth
    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CNT_W'(DEPTH));

    // R7: a write at capacity raises the overflow flag
    assert_drop_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && ((fifo_en && fifo_count == CNT_W'(DEPTH)) || (!fifo_en && fifo_count != '0))
        |=> overflow);

    // R7: overflow is sticky
    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R8: a fresh trigger interrupt comes with occupancy below the threshold
    assert_trig_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) && $stable(irq_en) && fifo_en && $stable(fifo_en) && !halfdup_en
        && $stable(halfdup_en) && $stable(trig_level) && !$past(wr_en)
        |-> fifo_count < trig_level);

    // R10: in half-duplex mode a fresh interrupt comes only with the shifter idle
    assert_halfdup_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) && $stable(irq_en) && halfdup_en && $stable(halfdup_en)
        |-> tsr_empty);

endmodule

bind uart_txq uart_txq_chk #(.DEPTH(DEPTH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_en    (fifo_en),
    .halfdup_en (halfdup_en),
    .trig_level (trig_level),
    .irq_en     (irq_en),
    .wr_en      (wr_en),
    .txd        (txd),
    .tsr_empty  (tsr_empty),
    .irq        (irq),
    .overflow   (overflow),
    .fifo_count (fifo_count)
);

// File: tb/uart_txq_tb_top.sv
`timescale 1ns/1ps
module uart_txq_tb_top;

    localparam int DEPTH  = 8;
    localparam int DATA_W = 8;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fifo_en = 1'b1;
    logic              os8_mode = 1'b1;
    logic              halfdup_en = 1'b0;
    logic [CNT_W-1:0]  trig_level = '0;
    logic              irq_en = 1'b0;
    logic              tick = 1'b0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              irq_ack = 1'b0;
    logic              txd;
    logic              thr_empty;
    logic              tsr_empty;
    logic              irq;
    logic              overflow;
    logic [CNT_W-1:0]  fifo_count;

    int  total = 0;
    int  bad = 0;
    int  busy_ticks = 0;
    int  period = 8;
    bit  tick_run = 1'b0;

    always #2 clk = ~clk;

    uart_txq #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .os8_mode(os8_mode),
        .halfdup_en(halfdup_en), .trig_level(trig_level), .irq_en(irq_en),
        .tick(tick), .wr_en(wr_en), .wr_data(wr_data), .irq_ack(irq_ack),
        .txd(txd), .thr_empty(thr_empty), .tsr_empty(tsr_empty), .irq(irq),
        .overflow(overflow), .fifo_count(fifo_count)
    );

    // tick every second clock; count ticks the shifter will consume
    initial begin
        forever begin
            @(negedge clk);
            tick = tick_run ? ~tick : 1'b0;
            if (tick && !tsr_empty) busy_ticks++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick_run = 1'b0; wr_en = 1'b0; irq_ack = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        busy_ticks = 0;
    endtask

    task automatic put(input logic [7:0] b);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic recv(output logic [7:0] b, input string tag);
        int n = 0;
        b = '0;
        while (txd && n < 20000) begin @(negedge clk); n++; end
        repeat (period) @(negedge clk);
        chk({tag, " start bit"}, int'(txd), 0);
        for (int i = 0; i < 8; i++) begin
            repeat (2 * period) @(negedge clk);
            b[i] = txd;
        end
        repeat (2 * period) @(negedge clk);
        chk({tag, " stop bit"}, int'(txd), 1);
    endtask

    task automatic wait_idle();
        int n = 0;
        while (!tsr_empty && n < 20000) begin @(negedge clk); n++; end
    endtask

    task automatic wait_irq();
        int n = 0;
        while (!irq && n < 40000) begin @(negedge clk); n++; end
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) & 8'hFF);
    endfunction

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired act=1 exp=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] got;

        // ---- R1 reset state
        do_reset();
        chk("R1 txd", int'(txd), 1);
        chk("R1 thr_empty", int'(thr_empty), 1);
        chk("R1 tsr_empty", int'(tsr_empty), 1);
        chk("R1 irq", int'(irq), 0);
        chk("R1 overflow", int'(overflow), 0);
        chk("R1 fifo_count", int'(fifo_count), 0);

        // ---- R2 / R3 / R5 single frame in both tick rates
        for (int m = 0; m < 2; m++) begin
            os8_mode = (m == 0);
            period = os8_mode ? 8 : 16;
            fifo_en = 1'b1;
            do_reset();
            tick_run = 1'b1;
            put(m == 0 ? 8'hA5 : 8'h3C);
            recv(got, "R2 frame");
            chk("R2 data LSB first", int'(got), m == 0 ? 'hA5 : 'h3C);
            chk("R5 tsr_empty low during stop bit", int'(tsr_empty), 0);
            wait_idle();
            chk("R3 ticks per frame", busy_ticks, 10 * period);
            chk("R2 line idles high", int'(txd), 1);
        end

        // ---- R4 / R5 / R7 queue fill, order, overflow
        os8_mode = 1'b1; period = 8; fifo_en = 1'b1;
        do_reset();
        for (int i = 0; i <= DEPTH; i++) put(pat(i));
        @(negedge clk);
        chk("R4 count at capacity", int'(fifo_count), DEPTH);
        chk("R5 thr_empty low when queued", int'(thr_empty), 0);
        chk("R5 tsr_empty low when loaded", int'(tsr_empty), 0);
        chk("R7 no overflow yet", int'(overflow), 0);
        put(8'hEE);
        @(negedge clk);
        chk("R7 overflow after drop", int'(overflow), 1);
        chk("R7 count unchanged by drop", int'(fifo_count), DEPTH);
        tick_run = 1'b1;
        for (int i = 0; i <= DEPTH; i++) begin
            recv(got, "R4 drain");
            chk("R4 write order", int'(got), int'(pat(i)));
        end
        wait_idle();
        chk("R5 thr_empty after drain", int'(thr_empty), 1);
        chk("R5 tsr_empty after drain", int'(tsr_empty), 1);
        chk("R7 overflow sticky", int'(overflow), 1);

        // ---- R6 / R7 single holding byte
        fifo_en = 1'b0;
        do_reset();
        put(8'h81);
        @(negedge clk);
        chk("R6 thr_empty after move", int'(thr_empty), 1);
        chk("R6 shifter loaded", int'(tsr_empty), 0);
        put(8'h7E);
        chk("R6 holding full", int'(thr_empty), 0);
        chk("R6 holding count", int'(fifo_count), 1);
        chk("R7 no overflow", int'(overflow), 0);
        put(8'h11);
        chk("R7 overflow one-byte mode", int'(overflow), 1);
        tick_run = 1'b1;
        recv(got, "R6 first");
        chk("R6 first byte", int'(got), 'h81);
        recv(got, "R6 second");
        chk("R6 second byte", int'(got), 'h7E);
        chk("R6 holding empty while shifting", int'(thr_empty), 1);
        chk("R6 shifter busy", int'(tsr_empty), 0);
        wait_idle();
        chk("R7 dropped byte never sent", int'(tsr_empty && fifo_count == 0), 1);

        // ---- R8 trigger sweep
        fifo_en = 1'b1; irq_en = 1'b1;
        for (int t = 1; t <= DEPTH; t++) begin
            trig_level = CNT_W'(t);
            do_reset();
            for (int i = 0; i <= DEPTH; i++) put(pat(i + t));
            ack();
            @(negedge clk);
            chk("R12 ack clears pending", int'(irq), 0);
            tick_run = 1'b1;
            wait_irq();
            chk("R8 irq raised", int'(irq), 1);
            chk("R8 count at first irq", int'(fifo_count), t - 1);
        end

        // ---- R11 gating
        trig_level = CNT_W'(4); irq_en = 1'b0;
        do_reset();
        for (int i = 0; i <= DEPTH; i++) put(pat(i));
        ack();
        tick_run = 1'b1;
        begin
            int n = 0;
            while (fifo_count >= CNT_W'(4) && n < 40000) begin @(negedge clk); n++; end
        end
        repeat (3) @(negedge clk);
        chk("R11 masked irq", int'(irq), 0);
        irq_en = 1'b1;
        @(negedge clk);
        chk("R11 pending shown when enabled", int'(irq), 1);
        ack();
        chk("R12 ack clears irq", int'(irq), 0);

        // ---- R9 / R12 one-byte source and clear by write
        fifo_en = 1'b0; irq_en = 1'b1;
        do_reset();
        put(8'h42);
        repeat (3) @(negedge clk);
        chk("R9 irq on holding empty", int'(irq), 1);
        put(8'h24);
        chk("R12 write clears irq", int'(irq), 0);
        repeat (5) @(negedge clk);
        chk("R9 no irq with holding full", int'(irq), 0);

        // ---- R10 half-duplex source versus normal source
        for (int h = 0; h < 2; h++) begin
            fifo_en = 1'b1; halfdup_en = (h == 1); irq_en = 1'b1;
            trig_level = (h == 1) ? CNT_W'(DEPTH) : CNT_W'(1);
            do_reset();
            put(8'h5A);
            put(8'hC3);
            ack();
            tick_run = 1'b1;
            wait_irq();
            if (h == 1) begin
                chk("R10 irq only after last stop", int'(tsr_empty), 1);
                chk("R10 ticks before irq", busy_ticks, 2 * 10 * 8);
                chk("R10 queue empty at irq", int'(fifo_count), 0);
            end else begin
                chk("R8 normal source fires while shifting", int'(tsr_empty), 0);
                chk("R8 normal source count", int'(fifo_count), 0);
            end
        end
        halfdup_en = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule